// File: doc/BRIEF.md
# Dual-Port Burst-Two SRAM Front End

This block is the device-side control for a synchronous SRAM with two separate data ports. A read port and a write port share one address bus. Every access moves an uninterruptible burst of two data words that goes to a fixed, aligned pair of array locations. The block runs on one clock at twice the external K rate. An input phase flag tells it which edges are K edges and which are K# edges. Read requests take their address on a K edge. Write requests take their address on the following K# edge, so both ports can start a new burst on every K edge.

Write data passes through a write register that holds the newest completed burst until it is committed to the array. Reads look past that register: a read of an address whose write is still pending gets the pending bytes merged over the array contents, byte by byte. The read data bus has a registered enable that stands in for a tri-state control. The enable is high only while burst words are being delivered, and the data lines are held at zero otherwise.

Top module: `dual_burst_sram`

## Requirements
- R1: After a synchronous reset, `rdata_oe` is 0 and `rdata` is all zeros.
- R2: A read is requested when `rd_sel_n` is 0 on a K edge (a clock edge with `k_phase`=1), and `addr` is taken on that same edge. If that is edge E, the first word appears on `rdata` after edge E+3, which is a K# edge, and the second word after edge E+4. `rdata_oe` is 1 for exactly those two clocks unless another burst follows.
- R3: A write is requested when `wr_sel_n` is 0 on a K edge. The first data word and its byte enables are taken on that edge. The write address, second word and second byte enables are taken on the K# edge that follows.
- R4: For burst address A, the first word of a burst is array word 2A and the second word is array word 2A+1, for both reads and writes. The order is fixed.
- R5: `wbe_n` bit b (active low) enables byte b (bits 8b+7..8b) of the word presented with it. A byte whose enable is 1 keeps its previous contents.
- R6: A read requested on K edge E returns data that includes every write requested on a K edge at or before E, with each write's byte enables applied in request order. This holds even when the write came on the previous K edge or on the same edge and is not yet in the array.
- R7: A read and a write may each be requested on every K edge. Reads on consecutive K edges give a continuous stream of words with `rdata_oe` held high.
- R8: In any clock in which no burst word is being delivered, `rdata_oe` is 0 and `rdata` is zero.
- R9: On a K edge with `wr_sel_n`=1, the values on `addr`, `wdata` and `wbe_n` during that K period change no memory contents. On a K edge with `rd_sel_n`=1, no burst is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the K rate |
| rst | input | 1 | Synchronous active-high reset |
| k_phase | input | 1 | 1 when the coming rising edge is a K edge, 0 for a K# edge; must alternate |
| rd_sel_n | input | 1 | Active-low read request, sampled on K edges |
| wr_sel_n | input | 1 | Active-low write request, sampled on K edges |
| addr | input | ADDR_W | Shared burst address: read address on K edges, write address on K# edges |
| wdata | input | BYTE_W*BYTES | Write data word, one per edge |
| wbe_n | input | BYTES | Active-low byte write enables for the word on `wdata` |
| rdata | output | BYTE_W*BYTES | Read data word, one per edge during a burst, zero otherwise |
| rdata_oe | output | 1 | Drive enable for the read data bus |

## Verification
The bench goes after the forwarding corner cases. A read on the K edge right after a write to the same pair, and a read on the same K edge as that write, would return stale array data if the pending register were not consulted. Forwarding that ignored byte enables would instead overwrite untouched bytes with whatever was on `wdata`. Every pair of byte-enable patterns is swept on every address, so a swapped word order or a misplaced byte lane shows up as a wrong half of the returned burst. Long runs of concurrent reads and writes catch an enable that drops between back-to-back bursts. Writes with `wr_sel_n` high catch a design that commits data without a request.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

  // words moved by one burst; the burst address selects an aligned pair
  localparam int unsigned WORDS_PER_BURST = 2;

  // read output sequencer
  typedef enum logic [1:0] {
    OUT_IDLE   = 2'd0,
    OUT_FIRST  = 2'd1,
    OUT_SECOND = 2'd2
  } out_state_e;

endpackage

// File: rtl/dpb_write_stage.sv
module dpb_write_stage #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned BYTES  = 2,
  localparam int unsigned DATA_W = BYTE_W * BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  k_phase,
  input  logic                  wr_sel_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [BYTES-1:0]      wbe_n,
  output logic                  pend_v,
  output logic [ADDR_W-1:0]     pend_addr,
  output logic [2*DATA_W-1:0]   pend_data,
  output logic [2*BYTES-1:0]    pend_be,
  output logic                  commit
);

  // half-collected burst: first word taken on the K edge
  logic                col_v;
  logic [DATA_W-1:0]   col_data;
  logic [BYTES-1:0]    col_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_v     <= 1'b0;
      col_data  <= '0;
      col_be    <= '0;
      pend_v    <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      pend_be   <= '0;
    end else if (k_phase) begin
      col_v <= ~wr_sel_n;
      if (!wr_sel_n) begin
        col_data <= wdata;
        col_be   <= ~wbe_n;
      end
    end else begin
      // K# edge: complete the burst; the previous one commits on this edge
      pend_v <= col_v;
      if (col_v) begin
        pend_addr <= addr;
        pend_data <= {wdata, col_data};
        pend_be   <= {~wbe_n, col_be};
      end
    end
  end

  // the completed burst is written to the array on the next K# edge
  assign commit = pend_v & ~k_phase;

  // R3: a request taken on K yields a complete pending burst after the K# edge
  assert_wr_addr_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (col_v && !k_phase) |=> pend_v);

endmodule

// File: rtl/dpb_array.sv
module dpb_array #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DEPTH = 1 << ADDR_W,
  localparam int unsigned WIDTH = LANE_W * LANES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [ADDR_W-1:0]  waddr,
  input  logic [WIDTH-1:0]   wdata,
  input  logic [LANES-1:0]   wbe,
  input  logic               re,
  input  logic [ADDR_W-1:0]  raddr,
  output logic [WIDTH-1:0]   rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // byte-lane write, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (wbe[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
      end
    end
    if (re) rdata <= mem[raddr];
  end

  // R7: commits (K#) and lookups (K) never share an edge
  assert_no_port_clash_R7: assert property (@(posedge clk) disable iff (rst)
    !(we && re));

endmodule

// File: rtl/dpb_read_stage.sv
module dpb_read_stage
  import dpb_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned BYTES  = 2,
  localparam int unsigned DATA_W = BYTE_W * BYTES,
  localparam int unsigned LANES  = WORDS_PER_BURST * BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  k_phase,
  input  logic                  rd_sel_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  pend_v,
  input  logic [ADDR_W-1:0]     pend_addr,
  input  logic [2*DATA_W-1:0]   pend_data,
  input  logic [LANES-1:0]      pend_be,
  output logic                  ram_re,
  output logic [ADDR_W-1:0]     ram_raddr,
  input  logic [2*DATA_W-1:0]   ram_q,
  output logic [DATA_W-1:0]     rdata,
  output logic                  rdata_oe
);

  logic                 req_v;
  logic [ADDR_W-1:0]    req_addr;
  logic                 look_v;
  logic                 fwd_hit;
  logic [2*DATA_W-1:0]  fwd_data;
  logic [LANES-1:0]     fwd_be;
  logic [2*DATA_W-1:0]  merged;
  logic [DATA_W-1:0]    hold;
  out_state_e           state;

  assign ram_re    = req_v & k_phase;
  assign ram_raddr = req_addr;

  // pending bytes override array bytes lane by lane
  for (genvar i = 0; i < LANES; i++) begin : g_merge
    assign merged[i*BYTE_W +: BYTE_W] = (fwd_hit && fwd_be[i])
      ? fwd_data[i*BYTE_W +: BYTE_W] : ram_q[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_v    <= 1'b0;
      req_addr <= '0;
      look_v   <= 1'b0;
      fwd_hit  <= 1'b0;
      fwd_data <= '0;
      fwd_be   <= '0;
      hold     <= '0;
      state    <= OUT_IDLE;
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else if (k_phase) begin
      req_v    <= ~rd_sel_n;
      req_addr <= addr;
      look_v   <= req_v;
      fwd_hit  <= req_v && pend_v && (pend_addr == req_addr);
      fwd_data <= pend_data;
      fwd_be   <= pend_be;
      if (state == OUT_FIRST) begin
        rdata <= hold;
        state <= OUT_SECOND;
      end
    end else begin
      if (look_v) begin
        rdata    <= merged[DATA_W-1:0];
        hold     <= merged[2*DATA_W-1:DATA_W];
        state    <= OUT_FIRST;
        rdata_oe <= 1'b1;
      end else if (state == OUT_SECOND) begin
        rdata    <= '0;
        rdata_oe <= 1'b0;
        state    <= OUT_IDLE;
      end
    end
  end

  // R2: a burst always spans two clocks
  assert_oe_two_words_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(rdata_oe) |=> rdata_oe);
  // R2: delivery starts on a K# edge
  assert_oe_on_kbar_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(rdata_oe) |-> !$past(k_phase));
  // R7: a finished lookup always drives the bus on the next K#
  assert_lookup_drives_R7: assert property (@(posedge clk) disable iff (rst)
    (look_v && !k_phase) |=> rdata_oe);
  // R8: released bus carries no data
  assert_idle_bus_R8: assert property (@(posedge clk) disable iff (rst)
    !rdata_oe |-> (rdata == '0));

endmodule

// File: rtl/dual_burst_sram.sv
module dual_burst_sram #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned BYTES  = 2,
  localparam int unsigned DATA_W = BYTE_W * BYTES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               k_phase,
  input  logic               rd_sel_n,
  input  logic               wr_sel_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [BYTES-1:0]   wbe_n,
  output logic [DATA_W-1:0]  rdata,
  output logic               rdata_oe
);

  localparam int unsigned LANES = dpb_pkg::WORDS_PER_BURST * BYTES;

  logic                 pend_v;
  logic [ADDR_W-1:0]    pend_addr;
  logic [2*DATA_W-1:0]  pend_data;
  logic [LANES-1:0]     pend_be;
  logic                 commit;
  logic                 ram_re;
  logic [ADDR_W-1:0]    ram_raddr;
  logic [2*DATA_W-1:0]  ram_q;

  dpb_write_stage #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BYTES(BYTES)) u_wr (
    .clk(clk), .rst(rst), .k_phase(k_phase), .wr_sel_n(wr_sel_n),
    .addr(addr), .wdata(wdata), .wbe_n(wbe_n),
    .pend_v(pend_v), .pend_addr(pend_addr), .pend_data(pend_data),
    .pend_be(pend_be), .commit(commit)
  );

  dpb_array #(.ADDR_W(ADDR_W), .LANE_W(BYTE_W), .LANES(LANES)) u_mem (
    .clk(clk), .rst(rst),
    .we(commit), .waddr(pend_addr), .wdata(pend_data), .wbe(pend_be),
    .re(ram_re), .raddr(ram_raddr), .rdata(ram_q)
  );

  dpb_read_stage #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BYTES(BYTES)) u_rd (
    .clk(clk), .rst(rst), .k_phase(k_phase), .rd_sel_n(rd_sel_n), .addr(addr),
    .pend_v(pend_v), .pend_addr(pend_addr), .pend_data(pend_data), .pend_be(pend_be),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_q(ram_q),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // R2: K and K# edges must alternate
  assert_phase_alternates_R2: assert property (@(posedge clk) disable iff (rst)
    k_phase |=> !k_phase);

endmodule

// File: tb/dual_burst_sram_test.sv
module dual_burst_sram_test;

  localparam int CLK_P = 10;
  localparam int AW    = 4;
  localparam int NB    = 2;
  localparam int DW    = 8 * NB;
  localparam int PAIRS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          k_phase = 1'b0;
  logic          rd_sel_n = 1'b1;
  logic          wr_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NB-1:0] wbe_n = '1;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  dual_burst_sram #(.ADDR_W(AW), .BYTE_W(8), .BYTES(NB)) uut (
    .clk(clk), .rst(rst), .k_phase(k_phase), .rd_sel_n(rd_sel_n),
    .wr_sel_n(wr_sel_n), .addr(addr), .wdata(wdata), .wbe_n(wbe_n),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int ecnt     = 0;
  bit mon_on   = 1'b0;

  logic [DW-1:0] ref_mem [2*PAIRS];
  bit            exp_v   [16];
  logic [DW-1:0] exp_d   [16];
  string         exp_tag [16];

  always @(posedge clk) if (!rst) ecnt <= ecnt + 1;

  function automatic logic [DW-1:0] pat(int a, int w, int p);
    return DW'((a * 4369) ^ (p * 241) ^ (w * 32769) ^ (p << 9));
  endfunction

  task automatic ref_write(int word, logic [DW-1:0] d, logic [NB-1:0] be_n);
    for (int b = 0; b < NB; b++)
      if (!be_n[b]) ref_mem[word][8*b +: 8] = d[8*b +: 8];
  endtask

  // one K period: K edge then K# edge
  task automatic step_k(bit do_rd, logic [AW-1:0] ra, bit do_wr, logic [AW-1:0] wa,
                        logic [DW-1:0] d0, logic [NB-1:0] b0,
                        logic [DW-1:0] d1, logic [NB-1:0] b1, string tag);
    int e;
    @(negedge clk);
    e = ecnt + 1;
    k_phase = 1'b1; rd_sel_n = !do_rd; wr_sel_n = !do_wr;
    addr = ra; wdata = d0; wbe_n = b0;
    if (do_wr) begin
      ref_write(2*int'(wa), d0, b0);
      ref_write(2*int'(wa)+1, d1, b1);
    end
    if (do_rd) begin
      exp_v[(e+3)%16] = 1'b1; exp_d[(e+3)%16] = ref_mem[2*int'(ra)];   exp_tag[(e+3)%16] = tag;
      exp_v[(e+4)%16] = 1'b1; exp_d[(e+4)%16] = ref_mem[2*int'(ra)+1]; exp_tag[(e+4)%16] = tag;
    end
    @(negedge clk);
    k_phase = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    addr = wa; wdata = d1; wbe_n = b1;
  endtask

  // per-clock output check against the scheduled bursts
  always @(negedge clk) begin
    if (mon_on) begin
      int s;
      s = ecnt % 16;
      n_checks++;
      if (rdata_oe !== exp_v[s] || rdata !== (exp_v[s] ? exp_d[s] : '0)) begin
        n_fail++;
        $display("FAIL %s edge %0d: rdata_oe=%0b rdata=%h expected rdata_oe=%0b rdata=%h",
                 exp_tag[s], ecnt, rdata_oe, rdata, exp_v[s], exp_v[s] ? exp_d[s] : '0);
      end
      exp_v[s] = 1'b0; exp_tag[s] = "R8 idle";
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; exp_tag[i] = "R8 idle"; end
    for (int i = 0; i < 2*PAIRS; i++) ref_mem[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    // R1: reset state
    n_checks++;
    if (rdata_oe !== 1'b0 || rdata !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: rdata_oe=%0b rdata=%h expected rdata_oe=0 rdata=0000", rdata_oe, rdata);
    end
    mon_on = 1'b1;

    // R3 R4: full writes to every pair, then R2 R7 back-to-back reads
    for (int a = 0; a < PAIRS; a++)
      step_k(1'b0, '0, 1'b1, AW'(a), pat(a,0,0), '0, pat(a,1,0), '0, "R3");
    for (int a = 0; a < PAIRS; a++)
      step_k(1'b1, AW'(a), 1'b0, '0, '0, '1, '0, '1, "R2 R4 R7");
    repeat (3) step_k(1'b0, '0, 1'b0, '0, '0, '1, '0, '1, "R8");

    // R5 R6: every byte-enable pair on every address; read next K or same K
    for (int a = 0; a < PAIRS; a++)
      for (int b0 = 0; b0 < 4; b0++)
        for (int b1 = 0; b1 < 4; b1++) begin
          int p;
          p = 1 + a*16 + b0*4 + b1;
          if (((b0 + b1) % 2) == 1) begin
            step_k(1'b1, AW'(a), 1'b1, AW'(a), pat(a,0,p), NB'(b0), pat(a,1,p), NB'(b1), "R5 R6 same-edge");
          end else begin
            step_k(1'b0, '0, 1'b1, AW'(a), pat(a,0,p), NB'(b0), pat(a,1,p), NB'(b1), "R5");
            step_k(1'b1, AW'(a), 1'b0, '0, '0, '1, '0, '1, "R5 R6 next-edge");
          end
        end
    repeat (3) step_k(1'b0, '0, 1'b0, '0, '0, '1, '0, '1, "R8");

    // R7 R6: concurrent read and write on every K edge
    for (int i = 0; i < 128; i++)
      step_k(1'b1, AW'((i*7) % PAIRS), 1'b1, AW'((i*3+1) % PAIRS),
             pat(i,0,500+i), NB'(i % 4), pat(i,1,500+i), NB'((i/4) % 4), "R6 R7 concurrent");
    repeat (3) step_k(1'b0, '0, 1'b0, '0, '0, '1, '0, '1, "R8");

    // R9: data on the bus with wr_sel_n high must not land; reads gated off
    for (int a = 0; a < PAIRS; a++)
      step_k(1'b0, AW'(a), 1'b0, AW'(a), '1, '0, '1, '0, "R9");
    for (int a = 0; a < PAIRS; a++)
      step_k(1'b1, AW'(a), 1'b0, AW'(a), '1, '0, '1, '0, "R9 readback");
    repeat (4) step_k(1'b0, '0, 1'b0, '0, '0, '1, '0, '1, "R8");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule